// File: doc/BRIEF.md
# Microcoded Control Sequencer for an Accumulator CPU

This block is the control unit of a small accumulator machine with 4-bit opcodes. On every clock cycle it produces a 17-bit control word. The word enables the bus drivers and the register loads in the datapath: program counter, memory address register, memory, instruction register, accumulator, B register, ALU, output port and flag register. The word is a table lookup. The table is addressed by four inputs: the opcode held in the upper four bits of the instruction word, a micro-step counter, and the stored carry and zero flags.

Every instruction starts with the same two fetch steps. Its execute steps follow, and the counter then wraps back to fetch. The flag register is part of the block. It captures the ALU carry-out and zero result only in a step whose word requests a flag load. Conditional jumps read the stored flags. A halt opcode stops the sequencer until reset.

Top module: `ctl_sequencer`

## Requirements
- R1: While reset is held and right after it is released, the step index is 0, both stored flags are 0 and `halted` is 0.
- R2: Control word bit positions are as follows.
  - bit 0 pc_oe, bit 1 pc_inc, bit 2 pc_ld, bit 3 mar_ld
  - bit 4 mem_oe, bit 5 mem_we, bit 6 ir_oe, bit 7 ir_ld
  - bit 8 acc_oe, bit 9 acc_ld, bit 10 breg_ld, bit 11 breg_oe
  - bit 12 alu_oe, bit 13 alu_sub, bit 14 flg_ld, bit 15 out_ld, bit 16 halt
  - breg_oe is never asserted, and at most one bus-driving bit (pc_oe, mem_oe, ir_oe, acc_oe, breg_oe, alu_oe) is high in any cycle.
- R3: Unless the sequencer is halted, the step index advances by one on each clock, 0 up to 4, and then wraps to 0.
- R4: For every opcode and flag state, step 0 gives pc_oe|mar_ld and step 1 gives mem_oe|ir_ld|pc_inc.
- R5: The load and store opcodes produce these words.
  - Opcode 0001 (load from memory): step 2 gives ir_oe|mar_ld, step 3 gives mem_oe|acc_ld, step 4 gives 0.
  - Opcode 0101 (load immediate): step 2 gives ir_oe|acc_ld, and steps 3 and 4 give 0.
  - Opcode 0100 (store): step 2 gives ir_oe|mar_ld, step 3 gives acc_oe|mem_we, step 4 gives 0.
- R6: Opcode 0010 (add) gives ir_oe|mar_ld at step 2, mem_oe|breg_ld at step 3 and alu_oe|acc_ld|flg_ld at step 4. Opcode 0011 (subtract) gives the same words, except that alu_sub is also set at step 4.
- R7: The jump opcodes set ir_oe|pc_ld at step 2 and give 0 at steps 3 and 4.
  - Opcode 0110 always sets ir_oe|pc_ld at step 2.
  - Opcode 0111 sets it only when the stored carry is 1.
  - Opcode 1000 sets it only when the stored zero flag is 1.
  - When the tested flag is 0, step 2 gives 0.
- R8: Opcode 1110 gives acc_oe|out_ld at step 2 and 0 at steps 3 and 4. Opcode 0000 and the unused opcodes 1001 to 1101 give 0 at steps 2 to 4.
- R9: The stored flags take `alu_carry` and `alu_zero` at a clock edge only when the current word has flg_ld set. At any other edge they keep their value.
- R10: Opcode 1111 gives a word with only the halt bit at step 2. From then on the step index stays at 2 and the word stays halt-only, whatever the instruction word does, and `halted` goes to 1 one clock later. Only reset leaves this state.
- R11: Only the upper four bits of the instruction word select the opcode. The lower bits have no effect on the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_word | input | IR_W (8) | Instruction register contents; opcode in the upper four bits |
| alu_carry | input | 1 | ALU carry-out for the flag register |
| alu_zero | input | 1 | ALU zero result for the flag register |
| ctrl_word | output | 17 | Control word for the current step |
| step_idx | output | STEP_W (3) | Current micro-step index |
| flag_c | output | 1 | Stored carry flag |
| flag_z | output | 1 | Stored zero flag |
| halted | output | 1 | Sequencer has stopped on a halt |

## Verification
The bench sweeps all sixteen opcodes against all four flag states. Before each sweep it preloads the flags by running an add instruction with the chosen ALU inputs. During the opcode under test the ALU inputs are inverted. Because of this, a flag load outside the add and subtract result step shows up as a changed flag, and a conditional jump that reads the live ALU inputs instead of the stored flags shows up as a wrong word. The low bits of the instruction word differ from sweep to sweep, which exposes any decode that reads them. For the halt opcode, the bench keeps clocking after the halt step and then switches the instruction word to a jump. This tells a true freeze apart from a counter or table that keeps responding.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

   localparam int CW_W = 17;

   // control word bit positions
   localparam int B_PC_OE   = 0;
   localparam int B_PC_INC  = 1;
   localparam int B_PC_LD   = 2;
   localparam int B_MAR_LD  = 3;
   localparam int B_MEM_OE  = 4;
   localparam int B_MEM_WE  = 5;
   localparam int B_IR_OE   = 6;
   localparam int B_IR_LD   = 7;
   localparam int B_ACC_OE  = 8;
   localparam int B_ACC_LD  = 9;
   localparam int B_BREG_LD = 10;
   localparam int B_BREG_OE = 11;
   localparam int B_ALU_OE  = 12;
   localparam int B_ALU_SUB = 13;
   localparam int B_FLG_LD  = 14;
   localparam int B_OUT_LD  = 15;
   localparam int B_HALT    = 16;

   typedef enum logic [3:0] {
      OP_NOP  = 4'b0000,
      OP_LDM  = 4'b0001,
      OP_ADD  = 4'b0010,
      OP_SUBT = 4'b0011,
      OP_STM  = 4'b0100,
      OP_LDIM = 4'b0101,
      OP_JMP  = 4'b0110,
      OP_JCY  = 4'b0111,
      OP_JZR  = 4'b1000,
      OP_SHOW = 4'b1110,
      OP_STOP = 4'b1111
   } opcode_e;

   typedef logic [CW_W-1:0] cword_t;

   function automatic cword_t bit_of(input int b);
      cword_t w;
      w    = '0;
      w[b] = 1'b1;
      return w;
   endfunction

   // microcode contents, indexed by opcode, step, stored flags
   function automatic cword_t cw_lookup(input logic [3:0] op, input int st,
                                        input logic cf, input logic zf);
      cword_t w;
      w = '0;
      if (st == 0) begin
         w = bit_of(B_PC_OE) | bit_of(B_MAR_LD);
      end else if (st == 1) begin
         w = bit_of(B_MEM_OE) | bit_of(B_IR_LD) | bit_of(B_PC_INC);
      end else begin
         case (op)
            OP_LDM: begin
               if (st == 2) w = bit_of(B_IR_OE) | bit_of(B_MAR_LD);
               if (st == 3) w = bit_of(B_MEM_OE) | bit_of(B_ACC_LD);
            end
            OP_ADD, OP_SUBT: begin
               if (st == 2) w = bit_of(B_IR_OE) | bit_of(B_MAR_LD);
               if (st == 3) w = bit_of(B_MEM_OE) | bit_of(B_BREG_LD);
               if (st == 4) begin
                  w = bit_of(B_ALU_OE) | bit_of(B_ACC_LD) | bit_of(B_FLG_LD);
                  if (op == OP_SUBT) w = w | bit_of(B_ALU_SUB);
               end
            end
            OP_STM: begin
               if (st == 2) w = bit_of(B_IR_OE) | bit_of(B_MAR_LD);
               if (st == 3) w = bit_of(B_ACC_OE) | bit_of(B_MEM_WE);
            end
            OP_LDIM: if (st == 2) w = bit_of(B_IR_OE) | bit_of(B_ACC_LD);
            OP_JMP:  if (st == 2) w = bit_of(B_IR_OE) | bit_of(B_PC_LD);
            OP_JCY:  if (st == 2 && cf) w = bit_of(B_IR_OE) | bit_of(B_PC_LD);
            OP_JZR:  if (st == 2 && zf) w = bit_of(B_IR_OE) | bit_of(B_PC_LD);
            OP_SHOW: if (st == 2) w = bit_of(B_ACC_OE) | bit_of(B_OUT_LD);
            OP_STOP: if (st == 2) w = bit_of(B_HALT);
            default: w = '0;
         endcase
      end
      return w;
   endfunction

endpackage

// File: rtl/ctl_step_counter.sv
module ctl_step_counter #(
   parameter int STEPS  = 5,
   parameter int STEP_W = $clog2(STEPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   output logic [STEP_W-1:0] step
);
   localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

   initial begin
      assert (STEPS >= 5 && (1 << STEP_W) >= STEPS)
         else $error("step counter: STEPS/STEP_W out of range");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)            step <= '0;
      else if (hold)         step <= step;
      else if (step == LAST) step <= '0;
      else                   step <= step + 1'b1;
   end

   a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && step == LAST) |=> step == '0);
   a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && step != LAST) |=> step == $past(step) + 1'b1);
   a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(step));
endmodule

// File: rtl/ctl_flag_reg.sv
module ctl_flag_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic ld,
   input  logic c_in,
   input  logic z_in,
   output logic c_q,
   output logic z_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         c_q <= 1'b0;
         z_q <= 1'b0;
      end else if (ld) begin
         c_q <= c_in;
         z_q <= z_in;
      end
   end

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> ($stable(c_q) && $stable(z_q)));
   a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (c_q == $past(c_in) && z_q == $past(z_in)));
endmodule

// File: rtl/ctl_microcode_rom.sv
module ctl_microcode_rom
   import ctl_pkg::*;
#(
   parameter int STEP_W    = 3,
   parameter bit TABLE_ROM = 1'b1
) (
   input  logic [3:0]        op,
   input  logic [STEP_W-1:0] step,
   input  logic              cf,
   input  logic              zf,
   output cword_t            word
);
   localparam int AW    = 4 + STEP_W + 2;
   localparam int DEPTH = 1 << AW;

   initial begin
      assert (STEP_W >= 3 && STEP_W <= 4)
         else $error("microcode rom: STEP_W out of range");
   end

   generate
      if (TABLE_ROM) begin : g_table
         cword_t          rom [DEPTH];
         logic [AW-1:0]   addr;
         for (genvar a = 0; a < DEPTH; a++) begin : g_ent
            localparam logic [AW-1:0] A = AW'(a);
            assign rom[a] = cw_lookup(A[AW-1 -: 4], int'(A[STEP_W+1:2]), A[1], A[0]);
         end
         assign addr = {op, step, cf, zf};
         assign word = rom[addr];
      end else begin : g_logic
         always_comb word = cw_lookup(op, int'(step), cf, zf);
      end
   endgenerate
endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
   import ctl_pkg::*;
#(
   parameter int IR_W      = 8,
   parameter int STEPS     = 5,
   parameter int STEP_W    = $clog2(STEPS),
   parameter bit TABLE_ROM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IR_W-1:0]   ir_word,
   input  logic              alu_carry,
   input  logic              alu_zero,
   output logic [16:0]       ctrl_word,
   output logic [STEP_W-1:0] step_idx,
   output logic              flag_c,
   output logic              flag_z,
   output logic              halted
);
   localparam cword_t HALT_ONLY = cword_t'(1) << B_HALT;

   initial begin
      assert (IR_W >= 4) else $error("sequencer: IR_W must hold an opcode");
   end

   logic [3:0] opcode;
   cword_t     raw_word;
   logic       halted_q;
   logic       unused_low;

   assign opcode = ir_word[IR_W-1 -: 4];

   generate
      if (IR_W > 4) begin : g_low
         assign unused_low = ^ir_word[IR_W-5:0];
      end else begin : g_nolow
         assign unused_low = 1'b0;
      end
   endgenerate

   ctl_step_counter #(.STEPS(STEPS), .STEP_W(STEP_W)) u_step (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (raw_word[B_HALT] | halted_q),
      .step  (step_idx)
   );

   ctl_microcode_rom #(.STEP_W(STEP_W), .TABLE_ROM(TABLE_ROM)) u_rom (
      .op   (opcode),
      .step (step_idx),
      .cf   (flag_c),
      .zf   (flag_z),
      .word (raw_word)
   );

   assign ctrl_word = halted_q ? HALT_ONLY : raw_word;

   ctl_flag_reg u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (ctrl_word[B_FLG_LD]),
      .c_in  (alu_carry),
      .z_in  (alu_zero),
      .c_q   (flag_c),
      .z_q   (flag_z)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                 halted_q <= 1'b0;
      else if (raw_word[B_HALT])  halted_q <= 1'b1;
   end
   assign halted = halted_q;

   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && ctrl_word == HALT_ONLY));
   a_r4_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      (step_idx == '0 && !halted) |-> (ctrl_word[B_PC_OE] && ctrl_word[B_MAR_LD]));
   a_r2_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctrl_word[B_PC_OE], ctrl_word[B_MEM_OE], ctrl_word[B_IR_OE],
                ctrl_word[B_ACC_OE], ctrl_word[B_BREG_OE], ctrl_word[B_ALU_OE]}));
   a_r7_carry_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OP_JCY && step_idx == STEP_W'(2) && !flag_c && !halted)
         |-> !ctrl_word[B_PC_LD]);
   a_r7_zero_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OP_JZR && step_idx == STEP_W'(2) && !flag_z && !halted)
         |-> !ctrl_word[B_PC_LD]);
endmodule

// File: tb/ctl_sequencer_bench.sv
module ctl_sequencer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  ir_word = '0;
   logic        alu_carry = 1'b0;
   logic        alu_zero = 1'b0;
   logic [16:0] ctrl_word;
   logic [2:0]  step_idx;
   logic        flag_c, flag_z, halted;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ctl_sequencer u_ctl_sequencer (
      .clk(clk), .rst_n(rst_n), .ir_word(ir_word),
      .alu_carry(alu_carry), .alu_zero(alu_zero),
      .ctrl_word(ctrl_word), .step_idx(step_idx),
      .flag_c(flag_c), .flag_z(flag_z), .halted(halted)
   );

   function automatic logic [16:0] b(input int n);
      return 17'(1) << n;
   endfunction

   // expected word from the requirement text (R2 bit positions)
   function automatic logic [16:0] expect_word(input int op, input int s,
                                               input logic c, input logic z);
      if (s == 0) return b(0) | b(3);
      if (s == 1) return b(4) | b(7) | b(1);
      case (op)
         1:  return (s == 2) ? (b(6) | b(3)) : (s == 3) ? (b(4) | b(9)) : 17'd0;
         2, 3: begin
            if (s == 2) return b(6) | b(3);
            if (s == 3) return b(4) | b(10);
            return b(12) | b(9) | b(14) | ((op == 3) ? b(13) : 17'd0);
         end
         4:  return (s == 2) ? (b(6) | b(3)) : (s == 3) ? (b(8) | b(5)) : 17'd0;
         5:  return (s == 2) ? (b(6) | b(9)) : 17'd0;
         6:  return (s == 2) ? (b(6) | b(2)) : 17'd0;
         7:  return (s == 2 && c) ? (b(6) | b(2)) : 17'd0;
         8:  return (s == 2 && z) ? (b(6) | b(2)) : 17'd0;
         14: return (s == 2) ? (b(8) | b(15)) : 17'd0;
         15: return (s == 2) ? b(16) : 17'd0;
         default: return 17'd0;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick();
      tick();
      rst_n = 1'b1;
   endtask

   initial begin
      // R1: reset state
      ir_word = 8'h00;
      do_reset();
      check(step_idx == 3'd0, "R1 step", 32'(step_idx), 0);
      check(flag_c == 1'b0 && flag_z == 1'b0, "R1 flags", {flag_c, flag_z}, 0);
      check(halted == 1'b0, "R1 halted", 32'(halted), 0);

      for (int op = 0; op < 16; op++) begin
         for (int fl = 0; fl < 4; fl++) begin
            logic c, z, halt_seen;
            c = fl[1];
            z = fl[0];
            ir_word = 8'h0F;
            do_reset();
            // preload flags through an add (R6, R9)
            ir_word   = {4'b0010, 4'(op ^ 5)};
            alu_carry = c;
            alu_zero  = z;
            for (int s = 0; s < 5; s++) tick();
            check(flag_c == c && flag_z == z, "R9 capture", {flag_c, flag_z}, {c, z});
            check(step_idx == 3'd0, "R3 wrap", 32'(step_idx), 0);
            // opcode under test; low bits vary (R11), ALU inputs inverted
            ir_word   = {4'(op), 4'(op * 3 + fl)};
            alu_carry = ~c;
            alu_zero  = ~z;
            halt_seen = 1'b0;
            for (int s = 0; s < 5 && !halt_seen; s++) begin
               check(step_idx == 3'(s), "R3 step", 32'(step_idx), s);
               check(ctrl_word == expect_word(op, s, c, z),
                     (s < 2) ? "R4 fetch" :
                     (op == 7 || op == 8 || op == 6) ? "R7 jump" :
                     (op == 2 || op == 3) ? "R6 alu" :
                     (op == 1 || op == 4 || op == 5) ? "R5 move" :
                     (op == 15) ? "R10 halt" : "R8 out/idle R11",
                     32'(ctrl_word), 32'(expect_word(op, s, c, z)));
               check(ctrl_word[11] == 1'b0, "R2 unused driver", 32'(ctrl_word), 0);
               if (op == 15 && s == 2) halt_seen = 1'b1;
               else tick();
            end
            if (halt_seen) begin
               tick();
               check(halted == 1'b1, "R10 halted flag", 32'(halted), 1);
               tick();
               tick();
               ir_word = 8'h60;
               #1;
               check(step_idx == 3'd2, "R10 frozen step", 32'(step_idx), 2);
               check(ctrl_word == b(16), "R10 frozen word", 32'(ctrl_word), 32'(b(16)));
               check(flag_c == c && flag_z == z, "R9 hold in halt", {flag_c, flag_z}, {c, z});
            end else begin
               check(step_idx == 3'd0, "R3 wrap after op", 32'(step_idx), 0);
               if (op == 2 || op == 3)
                  check(flag_c == ~c && flag_z == ~z, "R9 reload", {flag_c, flag_z}, {~c, ~z});
               else
                  check(flag_c == c && flag_z == z, "R9 no load", {flag_c, flag_z}, {c, z});
               check(halted == 1'b0, "R10 not halted", 32'(halted), 0);
            end
         end
      end

      // reset leaves halt (R1, R10)
      do_reset();
      check(halted == 1'b0 && step_idx == 3'd0, "R1 reset after halt",
            {halted, step_idx}, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule